// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table held in memory. A requester presents the virtual address, the current table base value and a configuration bit that allows fine second-level tables. The request uses a valid/ready handshake. The walker then fetches one or two 32-bit descriptor words through a simple read port, where each read is a request held until it is acknowledged. It then reports the result for one cycle.

The first descriptor decides the path. A section completes the walk at once with a 1 MB mapping. A coarse table pointer or a fine table pointer leads to a second fetch that yields a 64 KB, 4 KB or 1 KB page. The result carries the physical address, a page kind code, the protection domain, the cacheable/bufferable pair, the access-permission field and a fault flag. Permission checking and caching of translations are left to the surrounding logic.

Top module: `pt_walker`

## Requirements
- R1: `reqReady` is high only while idle. It is low from the cycle after a request is accepted until the cycle after the result. `rspValid` is a single-cycle pulse for each accepted request.
- R2: The first read goes to address {reqBase[31:14], reqVa[31:20], 2'b00}.
- R3: A first descriptor whose bits [1:0] are 00 gives a fault response after exactly one read.
- R4: A first descriptor with bits [1:0] = 11 (fine table) gives a fault after one read when `reqFineEn` is 0. When `reqFineEn` is 1 it leads to a second read.
- R5: A first descriptor with bits [1:0] = 10 (section) completes after one read. The results are: kind 0, rspPa = {desc[31:20], va[19:0]}, rspCb = desc[3:2], rspAp = {6'b0, desc[11:10]}.
- R6: A first descriptor with bits [1:0] = 01 (coarse) causes a second read at {desc[31:10], va[19:12], 2'b00}.
- R7: An enabled fine descriptor causes a second read at {desc[31:12], va[19:10], 2'b00}.
- R8: A second descriptor with bits [1:0] = 01 is a large page: kind 1, rspPa = {d2[31:16], va[15:0]}, rspAp = d2[11:4]. A second descriptor with bits [1:0] = 10 is a small page: kind 2, rspPa = {d2[31:12], va[11:0]}, rspAp = d2[11:4]. Both take rspCb = d2[3:2].
- R9: A second descriptor with bits [1:0] = 11 is a tiny page: kind 3, rspPa = {d2[31:10], va[9:0]}, rspAp = {6'b0, d2[5:4]}, rspCb = d2[3:2].
- R10: A second descriptor with bits [1:0] = 00 gives a fault. On any fault, rspFault is 1 and rspPa, rspKind, rspDomain, rspCb and rspAp are all zero.
- R11: For every non-fault result, rspDomain equals bits [8:5] of the first descriptor.
- R12: `memReq` and `memAddr` stay unchanged while a read waits for `memAck`.
- R13: A synchronous high `rst` returns the walker to idle with `memReq` low, and no response follows for the walk that was cut off. The same holds when the reset arrives together with a memory acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, request accepted |
| reqVa | input | 32 | Virtual address |
| reqBase | input | 32 | Table base value (bits 31:14 used) |
| reqFineEn | input | 1 | Allow fine second-level tables |
| memReq | output | 1 | Descriptor read request |
| memAddr | output | 32 | Descriptor word address |
| memAck | input | 1 | Read data valid, read done |
| memData | input | 32 | Descriptor word |
| rspValid | output | 1 | Result pulse |
| rspPa | output | 32 | Physical address |
| rspKind | output | 2 | 0 section, 1 large, 2 small, 3 tiny |
| rspDomain | output | 4 | Protection domain |
| rspCb | output | 2 | Cacheable/bufferable bits |
| rspAp | output | 8 | Access-permission field |
| rspFault | output | 1 | Translation fault |

## Verification
Two functions can meet in one cycle. A memory acknowledge can complete a descriptor fetch in the same edge that a synchronous reset abandons the walk. The bench's memory model answers with zero wait states, and the bench raises `rst` in the cycle the acknowledge is presented. It then judges that no response pulse appears, that the read port falls idle and that a following walk translates correctly. The model also varies wait states per walk so that request holding is exercised against acknowledge timing.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  localparam int WORD_W   = 32;
  localparam int DOM_W    = 4;
  localparam int AP_W     = 8;
  localparam int BASE_LO  = 14;
  localparam int BASE_W   = WORD_W - BASE_LO;
  localparam int PTR_LO   = 10;
  localparam int PTR_W    = WORD_W - PTR_LO;

  localparam logic [1:0] L1_FAULT   = 2'b00;
  localparam logic [1:0] L1_COARSE  = 2'b01;
  localparam logic [1:0] L1_SECTION = 2'b10;
  localparam logic [1:0] L1_FINE    = 2'b11;

  localparam logic [1:0] L2_FAULT = 2'b00;
  localparam logic [1:0] L2_LARGE = 2'b01;
  localparam logic [1:0] L2_SMALL = 2'b10;
  localparam logic [1:0] L2_TINY  = 2'b11;

  localparam logic [1:0] KIND_SECTION = 2'd0;
  localparam logic [1:0] KIND_LARGE   = 2'd1;
  localparam logic [1:0] KIND_SMALL   = 2'd2;
  localparam logic [1:0] KIND_TINY    = 2'd3;

  typedef struct packed {
    logic [WORD_W-1:0] pa;
    logic [1:0]        kind;
    logic [DOM_W-1:0]  domain;
    logic [1:0]        cb;
    logic [AP_W-1:0]   ap;
    logic              fault;
  } walkResult_t;

  typedef struct packed {
    logic capReq;   // latch request fields
    logic capL1;    // latch first descriptor
    logic finL1;    // result from first descriptor
    logic finL2;    // result from second descriptor
    logic selL2;    // drive second-level address
  } walkStrobe_t;

  function automatic walkResult_t faultResult();
    walkResult_t r;
    r = '0;
    r.fault = 1'b1;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] firstAddr(input logic [BASE_W-1:0] baseHi,
                                                  input logic [WORD_W-1:0] va);
    return {baseHi, va[31:20], 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] coarseAddr(input logic [PTR_W-1:0] ptr,
                                                   input logic [WORD_W-1:0] va);
    return {ptr, va[19:12], 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] fineAddr(input logic [PTR_W-1:0] ptr,
                                                 input logic [WORD_W-1:0] va);
    return {ptr[PTR_W-1:2], va[19:10], 2'b00};
  endfunction

  function automatic walkResult_t decodeFirst(input logic [WORD_W-1:0] d,
                                              input logic [WORD_W-1:0] va);
    walkResult_t r;
    if (d[1:0] == L1_SECTION) begin
      r.pa     = {d[31:20], va[19:0]};
      r.kind   = KIND_SECTION;
      r.domain = d[8:5];
      r.cb     = d[3:2];
      r.ap     = {6'b0, d[11:10]};
      r.fault  = 1'b0;
    end else begin
      r = faultResult();
    end
    return r;
  endfunction

  function automatic walkResult_t decodeSecond(input logic [DOM_W-1:0] dom,
                                               input logic [WORD_W-1:0] d,
                                               input logic [WORD_W-1:0] va);
    walkResult_t r;
    r.domain = dom;
    r.cb     = d[3:2];
    r.fault  = 1'b0;
    unique case (d[1:0])
      L2_LARGE: begin
        r.pa   = {d[31:16], va[15:0]};
        r.kind = KIND_LARGE;
        r.ap   = d[11:4];
      end
      L2_SMALL: begin
        r.pa   = {d[31:12], va[11:0]};
        r.kind = KIND_SMALL;
        r.ap   = d[11:4];
      end
      L2_TINY: begin
        r.pa   = {d[31:10], va[9:0]};
        r.kind = KIND_TINY;
        r.ap   = {6'b0, d[5:4]};
      end
      default: r = faultResult();
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pt_walk_datapath.sv
module pt_walk_datapath
  import pt_walk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  walkStrobe_t       strobe,
  input  logic [WORD_W-1:0] reqVa,
  input  logic [WORD_W-1:0] reqBase,
  input  logic              reqFineEn,
  input  logic [WORD_W-1:0] memData,
  output logic [WORD_W-1:0] memAddr,
  output logic              l1Walk,
  output walkResult_t       result
);

  logic [WORD_W-1:0] vaReg;
  logic [BASE_W-1:0] baseHi;
  logic              fineEnReg;
  logic [PTR_W-1:0]  ptrReg;
  logic [DOM_W-1:0]  domReg;
  logic              ptrFine;
  walkResult_t       resReg;
  logic              unusedBaseLow;

  assign unusedBaseLow = ^reqBase[BASE_LO-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      vaReg     <= '0;
      baseHi    <= '0;
      fineEnReg <= 1'b0;
      ptrReg    <= '0;
      domReg    <= '0;
      ptrFine   <= 1'b0;
      resReg    <= '0;
    end else begin
      if (strobe.capReq) begin
        vaReg     <= reqVa;
        baseHi    <= reqBase[WORD_W-1:BASE_LO];
        fineEnReg <= reqFineEn;
      end
      if (strobe.capL1) begin
        ptrReg  <= memData[WORD_W-1:PTR_LO];
        domReg  <= memData[8:5];
        ptrFine <= (memData[1:0] == L1_FINE);
      end
      if (strobe.finL1) begin
        resReg <= decodeFirst(memData, vaReg);
      end else if (strobe.finL2) begin
        resReg <= decodeSecond(domReg, memData, vaReg);
      end
    end
  end

  assign l1Walk = (memData[1:0] == L1_COARSE) ||
                  ((memData[1:0] == L1_FINE) && fineEnReg);

  always_comb begin
    if (!strobe.selL2)
      memAddr = firstAddr(baseHi, vaReg);
    else if (ptrFine)
      memAddr = fineAddr(ptrReg, vaReg);
    else
      memAddr = coarseAddr(ptrReg, vaReg);
  end

  assign result = resReg;

  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    resReg.fault |-> (resReg.pa == '0 && resReg.kind == '0 && resReg.domain == '0 &&
                      resReg.cb == '0 && resReg.ap == '0)); // R10

  AST_TINY_AP_NARROW: assert property (@(posedge clk) disable iff (rst)
    (!resReg.fault && resReg.kind == KIND_TINY) |-> (resReg.ap[AP_W-1:2] == '0)); // R9

  AST_SECTION_AP_NARROW: assert property (@(posedge clk) disable iff (rst)
    (!resReg.fault && resReg.kind == KIND_SECTION) |-> (resReg.ap[AP_W-1:2] == '0)); // R5

endmodule

// File: rtl/pt_walk_control.sv
module pt_walk_control
  import pt_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        memAck,
  input  logic        l1Walk,
  output logic        reqReady,
  output logic        memReq,
  output logic        rspValid,
  output walkStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH1, ST_FETCH2, ST_REPLY} walkState_t;

  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.capReq = reqValid;
        if (reqValid) stateNext = ST_FETCH1;
      end
      ST_FETCH1: begin
        strobe.capL1 = memAck;
        strobe.finL1 = memAck && !l1Walk;
        if (memAck) stateNext = l1Walk ? ST_FETCH2 : ST_REPLY;
      end
      ST_FETCH2: begin
        strobe.selL2 = 1'b1;
        strobe.finL2 = memAck;
        if (memAck) stateNext = ST_REPLY;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign memReq   = (state == ST_FETCH1) || (state == ST_FETCH2);
  assign rspValid = (state == ST_REPLY);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> memReq); // R12

  AST_REPLY_PULSE: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid); // R1

  AST_BUSY_AT_REPLY: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> !reqReady); // R1

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> !memReq); // R13

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqVa,
  input  logic [31:0] reqBase,
  input  logic        reqFineEn,
  output logic        memReq,
  output logic [31:0] memAddr,
  input  logic        memAck,
  input  logic [31:0] memData,
  output logic        rspValid,
  output logic [31:0] rspPa,
  output logic [1:0]  rspKind,
  output logic [3:0]  rspDomain,
  output logic [1:0]  rspCb,
  output logic [7:0]  rspAp,
  output logic        rspFault
);

  walkStrobe_t strobe;
  walkResult_t result;
  logic        l1Walk;

  pt_walk_control u_control (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .memAck   (memAck),
    .l1Walk   (l1Walk),
    .reqReady (reqReady),
    .memReq   (memReq),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  pt_walk_datapath u_datapath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .reqVa     (reqVa),
    .reqBase   (reqBase),
    .reqFineEn (reqFineEn),
    .memData   (memData),
    .memAddr   (memAddr),
    .l1Walk    (l1Walk),
    .result    (result)
  );

  assign rspPa     = result.pa;
  assign rspKind   = result.kind;
  assign rspDomain = result.domain;
  assign rspCb     = result.cb;
  assign rspAp     = result.ap;
  assign rspFault  = result.fault;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> $stable(memAddr)); // R12

endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVa = '0;
  logic [31:0] reqBase = '0;
  logic        reqFineEn = 1'b0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memAck = 1'b0;
  logic [31:0] memData = '0;
  logic        rspValid;
  logic [31:0] rspPa;
  logic [1:0]  rspKind;
  logic [3:0]  rspDomain;
  logic [1:0]  rspCb;
  logic [7:0]  rspAp;
  logic        rspFault;

  always #2 clk = ~clk;

  pt_walker uut (.*);

  int checks = 0;
  int fails  = 0;

  // memory model
  logic [31:0] slotAddr [2];
  logic [31:0] slotData [2];
  logic [31:0] rdAddr [4];
  int          rdCnt = 0;
  int          waitStates = 0;
  int          waitCnt = 0;
  int          stabErr = 0;
  bit          pendPrev = 0;
  logic [31:0] prevAddr = '0;

  always @(negedge clk) begin
    bit newAck;
    newAck = 0;
    if (pendPrev && memReq && memAddr !== prevAddr) stabErr++;
    if (memAck) begin
      memAck  <= 1'b0;
      waitCnt <= 0;
    end else if (memReq && !rst) begin
      if (waitCnt >= waitStates) begin
        newAck = 1;
        memAck <= 1'b1;
        if (memAddr === slotAddr[0])      memData <= slotData[0];
        else if (memAddr === slotAddr[1]) memData <= slotData[1];
        else                              memData <= 32'h0;
        if (rdCnt < 4) rdAddr[rdCnt] = memAddr;
        rdCnt++;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end else begin
      waitCnt <= 0;
    end
    pendPrev = memReq && !newAck && !rst;
    prevAddr = memAddr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [31:0] gotPa;
  logic [1:0]  gotKind;
  logic [3:0]  gotDom;
  logic [1:0]  gotCb;
  logic [7:0]  gotAp;
  logic        gotFault;
  logic        gotValid;

  task automatic doWalk(input logic [31:0] va, input logic [31:0] base,
                        input bit fine, input int waits);
    int n;
    waitStates = waits;
    rdCnt = 0;
    stabErr = 0;
    @(negedge clk);
    reqVa = va; reqBase = base; reqFineEn = fine; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R1 busy after accept", {31'b0, reqReady}, 32'd0);
    n = 0;
    while (!rspValid && n < 60) begin
      @(negedge clk);
      n++;
    end
    gotValid = rspValid;
    gotPa = rspPa; gotKind = rspKind; gotDom = rspDomain;
    gotCb = rspCb; gotAp = rspAp; gotFault = rspFault;
    chk("R1 response pulse", {31'b0, gotValid}, 32'd1);
    @(negedge clk);
    chk("R1 pulse ends", {31'b0, rspValid}, 32'd0);
    chk("R1 ready again", {31'b0, reqReady}, 32'd1);
    chk("R12 request held stable", stabErr, 0);
  endtask

  task automatic expectFault(input string req, input int reads);
    chk({req, " fault flag"}, {31'b0, gotFault}, 32'd1);
    chk("R10 fault zero fields", {gotPa ^ 32'h0, 22'b0, gotKind, gotDom, gotCb} |
        {24'b0, gotAp}, 32'd0);
    chk({req, " read count"}, rdCnt, reads);
  endtask

  task automatic expectPage(input string req, input logic [31:0] pa, input logic [1:0] kind,
                            input logic [3:0] dom, input logic [1:0] cb,
                            input logic [7:0] ap, input int reads);
    chk({req, " no fault"}, {31'b0, gotFault}, 32'd0);
    chk({req, " pa"}, gotPa, pa);
    chk({req, " kind"}, {30'b0, gotKind}, {30'b0, kind});
    chk("R11 domain", {28'b0, gotDom}, {28'b0, dom});
    chk({req, " cb"}, {30'b0, gotCb}, {30'b0, cb});
    chk({req, " ap"}, {24'b0, gotAp}, {24'b0, ap});
    chk({req, " read count"}, rdCnt, reads);
  endtask

  function automatic logic [31:0] l1Of(input logic [31:0] base, input logic [31:0] va);
    return {base[31:14], va[31:20], 2'b00};
  endfunction

  task automatic testReset();
    chk("R13 reset ready", {31'b0, reqReady}, 32'd1);
    chk("R13 reset no read", {31'b0, memReq}, 32'd0);
    chk("R13 reset no response", {31'b0, rspValid}, 32'd0);
  endtask

  task automatic testSection();
    logic [31:0] va = 32'hABC1_2345, base = 32'h1234_5678, d1 = 32'h5550_094E;
    slotAddr[0] = l1Of(base, va); slotData[0] = d1;
    slotAddr[1] = 32'hFFFF_FFF0;  slotData[1] = 0;
    doWalk(va, base, 1'b0, 1);
    chk("R2 first address", rdAddr[0], l1Of(base, va));
    expectPage("R5 section", {d1[31:20], va[19:0]}, 2'd0, d1[8:5], d1[3:2],
               {6'b0, d1[11:10]}, 1);
  endtask

  task automatic testFirstFault();
    logic [31:0] va = 32'h0010_0000, base = 32'h4000_0000;
    slotAddr[0] = l1Of(base, va); slotData[0] = 32'h5550_094C;
    doWalk(va, base, 1'b1, 0);
    expectFault("R3 first-level fault", 1);
  endtask

  task automatic testFineOff();
    logic [31:0] va = 32'h7FF0_1234, base = 32'h0000_C000;
    slotAddr[0] = l1Of(base, va); slotData[0] = 32'h0ABC_D1E3;
    doWalk(va, base, 1'b0, 2);
    expectFault("R4 fine disabled", 1);
  endtask

  task automatic testCoarse(input logic [31:0] d2, input logic [1:0] kind, input int waits);
    logic [31:0] va = 32'h0047_8ABC, base = 32'h8000_0000, d1 = 32'h0012_3C61;
    logic [31:0] a2;
    logic [31:0] pa;
    a2 = {d1[31:10], va[19:12], 2'b00};
    slotAddr[0] = l1Of(base, va); slotData[0] = d1;
    slotAddr[1] = a2;             slotData[1] = d2;
    doWalk(va, base, 1'b0, waits);
    chk("R6 coarse address", rdAddr[1], a2);
    pa = (kind == 2'd1) ? {d2[31:16], va[15:0]} : {d2[31:12], va[11:0]};
    expectPage("R8 large/small page", pa, kind, d1[8:5], d2[3:2], d2[11:4], 2);
  endtask

  task automatic testFineTiny();
    logic [31:0] va = 32'h3216_5ABC, base = 32'h0123_4567;
    logic [31:0] d1 = 32'h0ABC_D1E3, d2 = 32'hCAFE_F7B7;
    logic [31:0] a2;
    a2 = {d1[31:12], va[19:10], 2'b00};
    slotAddr[0] = l1Of(base, va); slotData[0] = d1;
    slotAddr[1] = a2;             slotData[1] = d2;
    doWalk(va, base, 1'b1, 1);
    chk("R4 fine enabled second read", rdCnt, 2);
    chk("R7 fine address", rdAddr[1], a2);
    expectPage("R9 tiny page", {d2[31:10], va[9:0]}, 2'd3, d1[8:5], d2[3:2],
               {6'b0, d2[5:4]}, 2);
  endtask

  task automatic testSecondFault();
    logic [31:0] va = 32'h0047_8ABC, base = 32'h8000_0000, d1 = 32'h0012_3C61;
    slotAddr[0] = l1Of(base, va); slotData[0] = d1;
    slotAddr[1] = {d1[31:10], va[19:12], 2'b00}; slotData[1] = 32'hFFFF_FFFC;
    doWalk(va, base, 1'b0, 0);
    expectFault("R10 second-level fault", 2);
  endtask

  task automatic abortWalk(input int waits, input int delay);
    int seen;
    waitStates = waits;
    slotAddr[0] = l1Of(32'h1000_0000, 32'h0010_0000); slotData[0] = 32'h0010_0002;
    @(negedge clk);
    reqVa = 32'h0010_0000; reqBase = 32'h1000_0000; reqFineEn = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (delay) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R13 abort read dropped", {31'b0, memReq}, 32'd0);
    chk("R13 abort idle", {31'b0, reqReady}, 32'd1);
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (rspValid || memReq) seen++;
    end
    chk("R13 nothing after abort", seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    slotAddr[0] = '1; slotAddr[1] = '1; slotData[0] = 0; slotData[1] = 0;
    for (int i = 0; i < 4; i++) rdAddr[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testSection();
    testFirstFault();
    testFineOff();
    testCoarse(32'hBEEF_0A5D, 2'd1, 2);
    testCoarse(32'h1357_9F26, 2'd2, 0);
    testFineTiny();
    testSecondFault();
    abortWalk(4, 1);   // reset while read waits
    abortWalk(0, 0);   // reset in the cycle the acknowledge arrives
    testSection();     // fresh walk after both aborts
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule